// File: doc/BRIEF.md
# Execute-Stage Branch Resolver with Static Not-Taken Prediction

This block resolves conditional branches in the execute stage of a five-stage, in-order pipeline. The front end always assumes a branch falls through and keeps fetching at PC + 4. When a branch reaches execute, the block checks its condition against the two forwarded operand values. If the branch turns out to be taken, the guess was wrong. The block then raises a one-cycle redirect strobe that carries the target address, and a matching squash strobe that turns the instruction in decode into a bubble. The target is the fetch-time PC of the branch (the value before incrementing) plus its sign-extended immediate.

The block also keeps its own prediction statistics: branches resolved, correct guesses, wrong guesses, and a cycle counter. On every wrong guess the cycle counter takes one extra step as a penalty. A pipeline stall input freezes the branch bookkeeping, so a branch held in execute for several cycles is counted and redirected once, on the cycle it is finally accepted.

Top module: `br_resolve_unit`

## Requirements
- R1: While reset is high at a clock edge, every output is cleared to zero after that edge, and it stays zero until the first clock edge with reset low.
- R2: An instruction is treated as a branch only when its 2-bit type code equals 3 and its 8-bit control byte equals 0x05 (Branch bit 2 set, ALU-op bits 1:0 = 01). With any other type code or control byte, nothing is counted and nothing is redirected.
- R3: When the valid input is low, nothing is counted and nothing is redirected, whatever the other inputs are.
- R4: The 3-bit condition field selects when a branch is taken: 000 when the operands are equal, 001 when they differ, 100 when A < B as signed numbers, 101 when A >= B signed, 110 when A < B unsigned, 111 when A >= B unsigned. The codes 010 and 011 are never taken.
- R5: Each accepted branch adds one to the branch counter on the edge that samples it. If the branch is not taken, it also adds one to the correct-prediction counter, and no redirect is raised.
- R6: An accepted taken branch raises both the redirect and squash outputs for the one cycle after its sampling edge. In that same cycle, the target output holds the fetch PC plus the immediate, modulo 2^XLEN, and the misprediction counter has gone up by one. The target output holds its value at all other times.
- R7: Once out of reset, the cycle counter adds one on each clock edge, or two on an edge that accepts a taken branch.
- R8: While the stall input is high, a branch is not accepted: no counter except the cycle counter changes, and no redirect or squash is raised. The cycle counter still adds one.
- R9: The branch counter always equals the sum of the correct-prediction and misprediction counters, modulo 2^CW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Pipeline stall; holds branch bookkeeping |
| ex_valid_i | input | 1 | Execute-stage slot holds a real instruction |
| ex_type_i | input | 2 | Instruction format code (3 = branch format) |
| ex_ctrl_i | input | 8 | Packed control byte from decode |
| ex_pc_i | input | XLEN | PC captured when the instruction was fetched |
| ex_imm_i | input | XLEN | Sign-extended branch offset |
| ex_cond_i | input | 3 | Branch condition select |
| ex_opa_i | input | XLEN | First compare operand |
| ex_opb_i | input | XLEN | Second compare operand |
| redirect_o | output | 1 | One-cycle strobe: fetch must jump to target_o |
| target_o | output | XLEN | Redirect address |
| squash_o | output | 1 | One-cycle strobe: turn the decode slot into a bubble |
| br_count_o | output | CW | Branches resolved |
| hit_count_o | output | CW | Correct (not-taken) predictions |
| miss_count_o | output | CW | Mispredictions (taken branches) |
| cycle_count_o | output | CW | Cycles, plus one penalty per misprediction |

## Verification
Two updates can fall on the same clock edge: the normal one-cycle step of the cycle counter, and the penalty step of a misprediction. The bench provokes this by issuing taken branches, including several back to back. On each edge it measures the cycle counter's change and expects exactly two on an accepting taken edge and one otherwise. The same overlap is then tried with the stall input high while a taken branch is presented. There the penalty must vanish while the plain step remains, and the redirect must stay low.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int TYPE_W = 2;
  localparam int CTRL_W = 8;
  localparam int COND_W = 3;

  localparam logic [TYPE_W-1:0] TYPE_BRANCH = 2'd3;
  localparam logic [CTRL_W-1:0] CTRL_BRANCH = 8'h05;

  localparam logic [COND_W-1:0] COND_EQ  = 3'b000;
  localparam logic [COND_W-1:0] COND_NE  = 3'b001;
  localparam logic [COND_W-1:0] COND_LT  = 3'b100;
  localparam logic [COND_W-1:0] COND_GE  = 3'b101;
  localparam logic [COND_W-1:0] COND_LTU = 3'b110;
  localparam logic [COND_W-1:0] COND_GEU = 3'b111;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [COND_W-1:0] cond_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  output logic              taken_o
);
  logic equal;
  logic lt_signed;
  logic lt_unsigned;

  assign equal       = (opa_i == opb_i);
  assign lt_signed   = ($signed(opa_i) < $signed(opb_i));
  assign lt_unsigned = (opa_i < opb_i);

  always_comb begin
    case (cond_i)
      COND_EQ:  taken_o = equal;
      COND_NE:  taken_o = !equal;
      COND_LT:  taken_o = lt_signed;
      COND_GE:  taken_o = !lt_signed;
      COND_LTU: taken_o = lt_unsigned;
      COND_GEU: taken_o = !lt_unsigned;
      default:  taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_perf_counters.sv
module br_perf_counters #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          branch_ev_i,
  input  logic          miss_ev_i,
  output logic [CW-1:0] br_count_o,
  output logic [CW-1:0] hit_count_o,
  output logic [CW-1:0] miss_count_o,
  output logic [CW-1:0] cycle_count_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic hit_ev;
  assign hit_ev = branch_ev_i && !miss_ev_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      br_count_o    <= '0;
      hit_count_o   <= '0;
      miss_count_o  <= '0;
      cycle_count_o <= '0;
    end else begin
      cycle_count_o <= cycle_count_o + ONE + CW'(miss_ev_i);
      if (branch_ev_i) br_count_o   <= br_count_o + ONE;
      if (hit_ev)      hit_count_o  <= hit_count_o + ONE;
      if (miss_ev_i)   miss_count_o <= miss_count_o + ONE;
    end
  end
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
  import br_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stall_i,
  input  logic                ex_valid_i,
  input  logic [TYPE_W-1:0]   ex_type_i,
  input  logic [CTRL_W-1:0]   ex_ctrl_i,
  input  logic [XLEN-1:0]     ex_pc_i,
  input  logic [XLEN-1:0]     ex_imm_i,
  input  logic [COND_W-1:0]   ex_cond_i,
  input  logic [XLEN-1:0]     ex_opa_i,
  input  logic [XLEN-1:0]     ex_opb_i,
  output logic                redirect_o,
  output logic [XLEN-1:0]     target_o,
  output logic                squash_o,
  output logic [CW-1:0]       br_count_o,
  output logic [CW-1:0]       hit_count_o,
  output logic [CW-1:0]       miss_count_o,
  output logic [CW-1:0]       cycle_count_o
);
  logic is_branch;
  logic accept;
  logic cond_taken;
  logic mispredict;

  assign is_branch  = (ex_type_i == TYPE_BRANCH) && (ex_ctrl_i == CTRL_BRANCH);
  assign accept     = ex_valid_i && !stall_i && is_branch;
  assign mispredict = accept && cond_taken;

  br_cond_eval #(.XLEN(XLEN)) cond_i (
    .cond_i  (ex_cond_i),
    .opa_i   (ex_opa_i),
    .opb_i   (ex_opb_i),
    .taken_o (cond_taken)
  );

  // Redirect and squash are separate flops so each can be placed near its consumer.
  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_o <= 1'b0;
      squash_o   <= 1'b0;
      target_o   <= '0;
    end else begin
      redirect_o <= mispredict;
      squash_o   <= mispredict;
      if (mispredict) target_o <= ex_pc_i + ex_imm_i;
    end
  end

  br_perf_counters #(.CW(CW)) perf_i (
    .clk           (clk),
    .rst           (rst),
    .branch_ev_i   (accept),
    .miss_ev_i     (mispredict),
    .br_count_o    (br_count_o),
    .hit_count_o   (hit_count_o),
    .miss_count_o  (miss_count_o),
    .cycle_count_o (cycle_count_o)
  );
endmodule

// File: rtl/br_resolve_unit_chk.sv
module br_resolve_unit_chk #(
  parameter int XLEN = 32,
  parameter int CW   = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          stall_i,
  input logic          redirect_o,
  input logic          squash_o,
  input logic [CW-1:0] br_count_o,
  input logic [CW-1:0] hit_count_o,
  input logic [CW-1:0] miss_count_o,
  input logic [CW-1:0] cycle_count_o
);
  localparam int UNUSED_XLEN = XLEN;

  assert_sum_R9: assert property (@(posedge clk) disable iff (rst)
    br_count_o == CW'(hit_count_o + miss_count_o));

  assert_miss_step_R6: assert property (@(posedge clk) disable iff (rst)
    (redirect_o && squash_o) |-> (miss_count_o == CW'($past(miss_count_o) + CW'(1))));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> (!redirect_o && !squash_o && $stable(br_count_o)));

  assert_cycle_step_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cycle_count_o == CW'($past(cycle_count_o) + (redirect_o ? CW'(2) : CW'(1)))));

  assert_br_step_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (br_count_o == $past(br_count_o) || br_count_o == CW'($past(br_count_o) + CW'(1))));
endmodule

bind br_resolve_unit br_resolve_unit_chk #(.XLEN(XLEN), .CW(CW)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .stall_i       (stall_i),
  .redirect_o    (redirect_o),
  .squash_o      (squash_o),
  .br_count_o    (br_count_o),
  .hit_count_o   (hit_count_o),
  .miss_count_o  (miss_count_o),
  .cycle_count_o (cycle_count_o)
);

// File: tb/br_resolve_unit_tb_top.sv
module br_resolve_unit_tb_top;
  localparam int XLEN = 32;
  localparam int CW   = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            stall_i = 1'b0;
  logic            ex_valid_i = 1'b0;
  logic [1:0]      ex_type_i = '0;
  logic [7:0]      ex_ctrl_i = '0;
  logic [XLEN-1:0] ex_pc_i = '0;
  logic [XLEN-1:0] ex_imm_i = '0;
  logic [2:0]      ex_cond_i = '0;
  logic [XLEN-1:0] ex_opa_i = '0;
  logic [XLEN-1:0] ex_opb_i = '0;
  logic            redirect_o;
  logic [XLEN-1:0] target_o;
  logic            squash_o;
  logic [CW-1:0]   br_count_o, hit_count_o, miss_count_o, cycle_count_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int e_br = 0, e_hit = 0, e_miss = 0;
  logic [XLEN-1:0] e_target = '0;

  always #2 clk = ~clk;

  br_resolve_unit #(.XLEN(XLEN), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .stall_i(stall_i), .ex_valid_i(ex_valid_i),
    .ex_type_i(ex_type_i), .ex_ctrl_i(ex_ctrl_i), .ex_pc_i(ex_pc_i),
    .ex_imm_i(ex_imm_i), .ex_cond_i(ex_cond_i), .ex_opa_i(ex_opa_i),
    .ex_opb_i(ex_opb_i), .redirect_o(redirect_o), .target_o(target_o),
    .squash_o(squash_o), .br_count_o(br_count_o), .hit_count_o(hit_count_o),
    .miss_count_o(miss_count_o), .cycle_count_o(cycle_count_o)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_taken(logic [2:0] c, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    case (c)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) < $signed(b);
      3'b101: return $signed(a) >= $signed(b);
      3'b110: return a < b;
      3'b111: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  // Drives one cycle of stimulus just after an edge, then checks just after the next edge.
  task automatic issue(bit v, logic [1:0] ty, logic [7:0] cb, logic [XLEN-1:0] pc,
                       logic [XLEN-1:0] imm, logic [2:0] c, logic [XLEN-1:0] a,
                       logic [XLEN-1:0] b, bit st, string tag);
    logic [CW-1:0] cyc0;
    bit acc, tk;
    cyc0 = cycle_count_o;
    ex_valid_i = v; ex_type_i = ty; ex_ctrl_i = cb; ex_pc_i = pc; ex_imm_i = imm;
    ex_cond_i = c; ex_opa_i = a; ex_opb_i = b; stall_i = st;
    acc = v && !st && ty == 2'd3 && cb == 8'h05;
    tk  = acc && exp_taken(c, a, b);
    if (acc) e_br++;
    if (acc && !tk) e_hit++;
    if (tk) begin e_miss++; e_target = pc + imm; end
    @(posedge clk); #1;
    chk(tag, "redirect", 64'(redirect_o), 64'(tk));
    chk(tag, "squash", 64'(squash_o), 64'(tk));
    chk("R6", "target", 64'(target_o), 64'(e_target));
    chk("R5", "branch count", 64'(br_count_o), 64'(CW'(e_br)));
    chk("R5", "hit count", 64'(hit_count_o), 64'(CW'(e_hit)));
    chk("R6", "miss count", 64'(miss_count_o), 64'(CW'(e_miss)));
    chk("R7", "cycle step", 64'(CW'(cycle_count_o - cyc0)), 64'(tk ? 2 : 1));
    chk("R9", "count sum", 64'(br_count_o), 64'(CW'(hit_count_o + miss_count_o)));
  endtask

  initial begin
    logic [XLEN-1:0] vals [6];
    vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h5};
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state, before any edge with reset low
    chk("R1", "redirect", 64'(redirect_o), 0);
    chk("R1", "squash", 64'(squash_o), 0);
    chk("R1", "target", 64'(target_o), 0);
    chk("R1", "branch count", 64'(br_count_o), 0);
    chk("R1", "hit count", 64'(hit_count_o), 0);
    chk("R1", "miss count", 64'(miss_count_o), 0);
    chk("R1", "cycle count", 64'(cycle_count_o), 0);

    // R4: condition sweep over all codes and operand pairs
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          issue(1, 2'd3, 8'h05, 32'h1000 + 32'(c * 64 + i * 8 + j) * 4, 32'h40,
                3'(c), vals[i], vals[j], 0, "R4");

    // R3: bubbles with otherwise taken branches
    issue(0, 2'd3, 8'h05, 32'h2000, 32'h10, 3'b000, 32'h7, 32'h7, 0, "R3");
    issue(0, 2'd3, 8'h05, 32'h2004, 32'h10, 3'b001, 32'h7, 32'h8, 0, "R3");

    // R2: wrong type code or control byte
    for (int t = 0; t < 3; t++)
      issue(1, 2'(t), 8'h05, 32'h3000, 32'h8, 3'b000, 32'h1, 32'h1, 0, "R2");
    issue(1, 2'd3, 8'h04, 32'h3000, 32'h8, 3'b000, 32'h1, 32'h1, 0, "R2");
    issue(1, 2'd3, 8'h22, 32'h3000, 32'h8, 3'b000, 32'h1, 32'h1, 0, "R2");
    issue(1, 2'd3, 8'h88, 32'h3000, 32'h8, 3'b000, 32'h1, 32'h1, 0, "R2");

    // R8: stall over a taken branch, then the same branch released
    issue(1, 2'd3, 8'h05, 32'h4000, 32'h20, 3'b000, 32'h3, 32'h3, 1, "R8");
    issue(1, 2'd3, 8'h05, 32'h4000, 32'h20, 3'b000, 32'h3, 32'h3, 1, "R8");
    issue(1, 2'd3, 8'h05, 32'h4000, 32'h20, 3'b000, 32'h3, 32'h3, 0, "R6");
    issue(1, 2'd3, 8'h05, 32'h4010, 32'h20, 3'b001, 32'h3, 32'h3, 1, "R8");

    // R6: wrapping target and backward offset, back to back
    issue(1, 2'd3, 8'h05, 32'hFFFF_FFFC, 32'h8, 3'b001, 32'h0, 32'h1, 0, "R6");
    issue(1, 2'd3, 8'h05, 32'h0000_0100, 32'hFFFF_FFF0, 3'b110, 32'h0, 32'h1, 0, "R6");
    issue(1, 2'd3, 8'h05, 32'h0000_0200, 32'hFFFF_FE00, 3'b111, 32'h9, 32'h1, 0, "R6");
    // one-cycle pulse: idle cycle after taken branch
    issue(0, 2'd0, 8'h00, 32'h0, 32'h0, 3'b000, 32'h0, 32'h0, 0, "R6");
    issue(0, 2'd0, 8'h00, 32'h0, 32'h0, 3'b000, 32'h0, 32'h0, 0, "R7");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule